// File: doc/BRIEF.md
# Paged Instruction-Address Sequencer

This block produces the fetch address for a small 4-bit controller whose program store holds 10-bit words, grouped into 128-word pages across a 12-bit address space. The program counter steps forward once for each fetch. Decoded control strobes from the instruction decoder redirect it. An in-page jump replaces only the low seven bits. A long jump replaces the whole address. A one-word call lands on a fixed subroutine page, and a return pops a small hardware stack. Interrupt requests from four sources force the counter to a fixed vector address inside a reserved page.

The program store is modelled as a computed array with two read ports. One port returns the word at the fetch address. The other serves table reads: the decoder names any address in the map, and the block returns the low byte of the word held there. That byte is handed out over a valid/ready pair. A result stays on `tbl_data_o` with `tbl_valid_o` high until the consumer asserts `tbl_ready_i`. A new request is taken only while `tbl_req_rdy_o` is high, which is when no result is held or the held result is being consumed in the same cycle.

Top module: `pgseq_top`

## Requirements
- R1: After a synchronous active-high reset, `fetch_addr_o` is 0x000, `int_en_o` is 0, `tbl_valid_o` is 0 and `irq_ack_o` is 0.
- R2: `adv_i` loads the current address plus one in the next cycle. It crosses page boundaries freely, and 0xFFF wraps to 0x000.
- R3: `jmp_page_i` replaces address bits 6:0 with `op_off_i` and keeps bits 11:7. `jmp_long_i` loads all 12 bits from `op_addr_i`.
- R4: `call_spec_i` loads {page 2, `op_off_i`}, which is 0x100 plus the offset. It pushes the current address plus one onto the return stack, and it works from any page.
- R5: `ret_i` pops the return stack into the address. The stack is LIFO with four entries. A fifth push overwrites the oldest entry, so after five pushes p0..p4, five pops return p4, p3, p2, p1, p4.
- R6: An accepted interrupt loads its vector in the next cycle: `irq_req_i[0]` to 0x080, `[1]` to 0x084, `[2]` to 0x086 and `[3]` to 0x08C. In that same cycle `irq_ack_o` shows the one-hot bit of the served source for one cycle. The address that was current when the interrupt was accepted is pushed as the return address.
- R7: An interrupt is accepted only while `int_en_o` is 1. Bit 0 has the highest priority and bit 3 the lowest. Acceptance clears `int_en_o`. `ie_set_i` sets the enable and `ie_clr_i` clears it, with set winning if both are high.
- R8: An accepted interrupt takes precedence over any control strobe in the same cycle, and that strobe has no effect.
- R9: The word at address a is {a[11:10]^a[1:0], a[7:0]^{a[11:8],a[11:8]}^0x5A}. `fetch_word_o` always shows the word at `fetch_addr_o`.
- R10: An accepted table request for address {`tbl_page_i`, `tbl_off_i`} gives `tbl_valid_o`=1 in the next cycle, with `tbl_data_o` equal to bits 7:0 of that word. Any address in the map can be read. Valid and data hold until a cycle with `tbl_ready_i` high.
- R11: A table read changes neither the fetch address nor the return stack.
- R12: A table request made while `tbl_req_rdy_o` is 0 is ignored, and the held data stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| adv_i | input | 1 | Step to next address |
| jmp_page_i | input | 1 | In-page jump strobe |
| jmp_long_i | input | 1 | Full-address jump strobe |
| call_spec_i | input | 1 | One-word call into page 2 |
| ret_i | input | 1 | Return from subroutine or interrupt |
| op_off_i | input | 7 | Offset operand for in-page jump and special call |
| op_addr_i | input | 12 | Target of a long jump |
| ie_set_i | input | 1 | Set global interrupt enable |
| ie_clr_i | input | 1 | Clear global interrupt enable |
| irq_req_i | input | 4 | Interrupt requests (0 ext, 1 timer A, 2 timer B, 3 converter) |
| tbl_req_i | input | 1 | Table-read request |
| tbl_page_i | input | 5 | Page of table address |
| tbl_off_i | input | 7 | Offset of table address |
| tbl_req_rdy_o | output | 1 | Table request can be taken this cycle |
| tbl_valid_o | output | 1 | Table byte valid |
| tbl_ready_i | input | 1 | Consumer takes the table byte |
| tbl_data_o | output | 8 | Table byte |
| fetch_addr_o | output | 12 | Current fetch address |
| fetch_word_o | output | 10 | Program word at the fetch address |
| int_en_o | output | 1 | Global interrupt enable |
| irq_ack_o | output | 4 | One-hot pulse naming the served interrupt |

## Verification
The assertions assume that the decoder raises at most one of the five control strobes in a cycle. They also assume that a return is issued only after a matching push. The stimulus drives strobes one at a time from tasks and pairs every call and interrupt entry with a return, except in the overflow sequence, where the expected pop order is stated explicitly. Interrupt lines and a control strobe are raised together on purpose only in the precedence case. That case is legal input, because the interrupt wins.

// File: rtl/pgseq_pkg.sv
`timescale 1ns/1ps
package pgseq_pkg;
  localparam int PC_W   = 12;
  localparam int OFF_W  = 7;
  localparam int PAGE_W = PC_W - OFF_W;
  localparam int WORD_W = 10;
  localparam int BYTE_W = 8;
  localparam int NIRQ   = 4;
  localparam int STK_D  = 4;
  localparam logic [PAGE_W-1:0] SPEC_PAGE = PAGE_W'(2);
  // fixed vector per source, index = priority rank (0 highest)
  localparam logic [PC_W-1:0] VEC_TAB [NIRQ] = '{12'h080, 12'h084, 12'h086, 12'h08C};
endpackage

// File: rtl/prog_rom.sv
`timescale 1ns/1ps
module prog_rom #(
  parameter int AW    = 12,
  parameter int WW    = 10,
  parameter int NPORT = 2
) (
  input  logic [NPORT-1:0][AW-1:0] addr_i,
  output logic [NPORT-1:0][WW-1:0] data_o
);
  // content is computed from the address: hi 2 bits and low byte
  localparam int LO_W = WW - 2;
  generate
    for (genvar p = 0; p < NPORT; p++) begin : g_port
      logic [AW-1:0] a;
      assign a = addr_i[p];
      assign data_o[p] = {a[AW-1 -: 2] ^ a[1:0],
                          a[LO_W-1:0] ^ {2{a[AW-1 -: 4]}} ^ LO_W'(8'h5A)};
    end
  endgenerate
endmodule

// File: rtl/ret_stack.sv
`timescale 1ns/1ps
module ret_stack #(
  parameter int DEPTH = 4,
  parameter int W     = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] top
);
  localparam int PW = $clog2(DEPTH);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] sp;
  logic [PW-1:0] rd_ptr;

  // circular pointer: overflow silently overwrites the oldest slot
  assign rd_ptr = sp - PW'(1);
  assign top    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (rst)       sp <= '0;
    else if (push) sp <= sp + PW'(1);
    else if (pop)  sp <= rd_ptr;
  end

  always_ff @(posedge clk) begin
    if (push) mem[sp] <= din;
  end

  // R5
  push_pop_excl_chk: assert property (@(posedge clk) disable iff (rst) !(push && pop));
  // R5
  push_lands_on_top_chk: assert property (@(posedge clk) disable iff (rst)
    push |=> top == $past(din));
endmodule

// File: rtl/irq_arbiter.sv
`timescale 1ns/1ps
module irq_arbiter #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] req,
  output logic [N-1:0] grant
);
  logic [N:0] seen;
  assign seen[0] = 1'b0;
  generate
    for (genvar i = 0; i < N; i++) begin : g_pri
      assign grant[i]  = req[i] & ~seen[i];
      assign seen[i+1] = seen[i] | req[i];
    end
  endgenerate

  // R7
  grant_onehot_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(grant));
  // R7
  grant_when_req_chk: assert property (@(posedge clk) disable iff (rst)
    (|req) |-> (|(grant & req)));
endmodule

// File: rtl/pgseq_top.sv
`timescale 1ns/1ps
module pgseq_top
  import pgseq_pkg::*;
#(
  parameter int P_W   = PC_W,
  parameter int O_W   = OFF_W,
  parameter int W_W   = WORD_W,
  parameter int B_W   = BYTE_W,
  parameter int N_IRQ = NIRQ,
  parameter int S_D   = STK_D
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv_i,
  input  logic             jmp_page_i,
  input  logic             jmp_long_i,
  input  logic             call_spec_i,
  input  logic             ret_i,
  input  logic [O_W-1:0]   op_off_i,
  input  logic [P_W-1:0]   op_addr_i,
  input  logic             ie_set_i,
  input  logic             ie_clr_i,
  input  logic [N_IRQ-1:0] irq_req_i,
  input  logic             tbl_req_i,
  input  logic [P_W-O_W-1:0] tbl_page_i,
  input  logic [O_W-1:0]   tbl_off_i,
  output logic             tbl_req_rdy_o,
  output logic             tbl_valid_o,
  input  logic             tbl_ready_i,
  output logic [B_W-1:0]   tbl_data_o,
  output logic [P_W-1:0]   fetch_addr_o,
  output logic [W_W-1:0]   fetch_word_o,
  output logic             int_en_o,
  output logic [N_IRQ-1:0] irq_ack_o
);
  localparam int PG_W = P_W - O_W;

  logic [P_W-1:0]   pc_q, pc_d, pc_inc;
  logic             ie_q;
  logic [N_IRQ-1:0] grant, ack_q;
  logic             take;
  logic             push, pop;
  logic [P_W-1:0]   push_val, stk_top;
  logic [P_W-1:0]   vec_sel;
  logic [P_W-1:0]   tbl_addr;
  logic [1:0][P_W-1:0] rom_a;
  logic [1:0][W_W-1:0] rom_d;
  logic             tbl_acc;
  logic             tbl_v_q;
  logic [B_W-1:0]   tbl_d_q;

  irq_arbiter #(.N(N_IRQ)) u_arb (
    .clk(clk), .rst(rst), .req(irq_req_i), .grant(grant)
  );

  ret_stack #(.DEPTH(S_D), .W(P_W)) u_stk (
    .clk(clk), .rst(rst), .push(push), .pop(pop), .din(push_val), .top(stk_top)
  );

  assign tbl_addr = {tbl_page_i, tbl_off_i};
  assign rom_a[0] = pc_q;
  assign rom_a[1] = tbl_addr;

  prog_rom #(.AW(P_W), .WW(W_W), .NPORT(2)) u_rom (
    .addr_i(rom_a), .data_o(rom_d)
  );

  assign take   = ie_q && (|irq_req_i);
  assign pc_inc = pc_q + P_W'(1);

  always_comb begin
    vec_sel = '0;
    for (int i = 0; i < N_IRQ; i++)
      if (grant[i]) vec_sel = VEC_TAB[i];
  end

  // next-address selection; an accepted interrupt overrides all strobes
  always_comb begin
    pc_d     = pc_q;
    push     = 1'b0;
    pop      = 1'b0;
    push_val = pc_inc;
    if (take) begin
      pc_d     = vec_sel;
      push     = 1'b1;
      push_val = pc_q;
    end else if (adv_i) begin
      pc_d = pc_inc;
    end else if (jmp_page_i) begin
      pc_d = {pc_q[P_W-1:O_W], op_off_i};
    end else if (jmp_long_i) begin
      pc_d = op_addr_i;
    end else if (call_spec_i) begin
      pc_d = {SPEC_PAGE[PG_W-1:0], op_off_i};
      push = 1'b1;
    end else if (ret_i) begin
      pc_d = stk_top;
      pop  = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q  <= '0;
      ie_q  <= 1'b0;
      ack_q <= '0;
    end else begin
      pc_q  <= pc_d;
      ack_q <= take ? grant : '0;
      if (take)          ie_q <= 1'b0;
      else if (ie_set_i) ie_q <= 1'b1;
      else if (ie_clr_i) ie_q <= 1'b0;
    end
  end

  // table-read byte channel
  assign tbl_req_rdy_o = !tbl_v_q || tbl_ready_i;
  assign tbl_acc       = tbl_req_i && tbl_req_rdy_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      tbl_v_q <= 1'b0;
      tbl_d_q <= '0;
    end else if (tbl_acc) begin
      tbl_v_q <= 1'b1;
      tbl_d_q <= rom_d[1][B_W-1:0];
    end else if (tbl_ready_i) begin
      tbl_v_q <= 1'b0;
    end
  end

  assign fetch_addr_o = pc_q;
  assign fetch_word_o = rom_d[0];
  assign int_en_o     = ie_q;
  assign irq_ack_o    = ack_q;
  assign tbl_valid_o  = tbl_v_q;
  assign tbl_data_o   = tbl_d_q;

  // R8 input assumption: decoder raises one strobe at a time
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({adv_i, jmp_page_i, jmp_long_i, call_spec_i, ret_i}));
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (fetch_addr_o == '0) && !int_en_o && !tbl_valid_o && (irq_ack_o == '0));
  // R2
  advance_chk: assert property (@(posedge clk) disable iff (rst)
    (adv_i && !take) |=> fetch_addr_o == $past(fetch_addr_o) + P_W'(1));
  // R4
  spec_page_chk: assert property (@(posedge clk) disable iff (rst)
    (call_spec_i && !take) |=> fetch_addr_o[P_W-1:O_W] == SPEC_PAGE[PG_W-1:0]);
  // R7
  ack_onehot_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(irq_ack_o));
  // R7
  ie_cleared_chk: assert property (@(posedge clk) disable iff (rst)
    (|irq_ack_o) |-> !int_en_o);
  // R7
  no_entry_when_off_chk: assert property (@(posedge clk) disable iff (rst)
    !int_en_o |=> irq_ack_o == '0);
  generate
    for (genvar i = 0; i < N_IRQ; i++) begin : g_vchk
      // R6
      vector_chk: assert property (@(posedge clk) disable iff (rst)
        irq_ack_o[i] |-> fetch_addr_o == VEC_TAB[i]);
    end
  endgenerate
  // R9 both read ports see the same array
  rom_ports_agree_chk: assert property (@(posedge clk) disable iff (rst)
    (tbl_addr == fetch_addr_o) |-> rom_d[1] == fetch_word_o);
  // R10
  tbl_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (tbl_valid_o && !tbl_ready_i) |=> tbl_valid_o && $stable(tbl_data_o));
  // R11
  tbl_no_pc_move_chk: assert property (@(posedge clk) disable iff (rst)
    (tbl_req_i && !take && !adv_i && !jmp_page_i && !jmp_long_i && !call_spec_i && !ret_i)
      |=> $stable(fetch_addr_o));
endmodule

// File: tb/pgseq_top_test.sv
`timescale 1ns/1ps
module pgseq_top_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic adv, jpg, jlg, csp, rtn, ies, iec, treq, trdy;
  logic [6:0]  off;
  logic [11:0] addr;
  logic [3:0]  irq;
  logic [4:0]  tpg;
  logic [6:0]  tof;
  logic        req_rdy, tvalid, ien;
  logic [7:0]  tdata;
  logic [11:0] fa;
  logic [9:0]  fw;
  logic [3:0]  ack;
  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  pgseq_top uut (
    .clk(clk), .rst(rst), .adv_i(adv), .jmp_page_i(jpg), .jmp_long_i(jlg),
    .call_spec_i(csp), .ret_i(rtn), .op_off_i(off), .op_addr_i(addr),
    .ie_set_i(ies), .ie_clr_i(iec), .irq_req_i(irq), .tbl_req_i(treq),
    .tbl_page_i(tpg), .tbl_off_i(tof), .tbl_req_rdy_o(req_rdy),
    .tbl_valid_o(tvalid), .tbl_ready_i(trdy), .tbl_data_o(tdata),
    .fetch_addr_o(fa), .fetch_word_o(fw), .int_en_o(ien), .irq_ack_o(ack)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int rom_exp(input int a);
    int hi, lo;
    hi = ((a >> 10) & 3) ^ (a & 3);
    lo = (a & 255) ^ (((a >> 8) & 15) * 17) ^ 'h5A;
    return hi * 256 + lo;
  endfunction

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic idle();
    adv = 0; jpg = 0; jlg = 0; csp = 0; rtn = 0; ies = 0; iec = 0;
    treq = 0; trdy = 0; irq = '0; off = '0; addr = '0; tpg = '0; tof = '0;
  endtask

  task automatic go_long(input int a);
    jlg = 1; addr = 12'(a); tick(); jlg = 0;
  endtask

  task automatic do_call(input int o);
    csp = 1; off = 7'(o); tick(); csp = 0;
  endtask

  task automatic do_ret();
    rtn = 1; tick(); rtn = 0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    int p [5];
    int cur, exp, low, a2;
    idle();
    rst = 1;
    repeat (3) tick();
    // R1
    chk(fa == 0 && ien == 0 && tvalid == 0 && ack == 0, "R1 reset state", fa, 0);
    rst = 0;

    // R2 / R9: full sweep of the map, including the wrap at the top
    for (int i = 0; i < 4096; i++) begin
      chk(fw == rom_exp(i), "R9 fetch word", fw, rom_exp(i));
      adv = 1; tick(); adv = 0;
      chk(fa == ((i + 1) % 4096), "R2 advance", fa, (i + 1) % 4096);
    end

    // R3: long jump then every in-page offset
    go_long('hA85);
    chk(fa == 'hA85, "R3 long jump", fa, 'hA85);
    for (int o = 0; o < 128; o++) begin
      jpg = 1; off = 7'(o); tick(); jpg = 0;
      chk(fa == ('hA80 | o), "R3 page jump", fa, 'hA80 | o);
    end

    // R4 / R5: special call from many pages, each offset
    for (int o = 0; o < 128; o++) begin
      cur = (o * 37 + 5) % 4096;
      go_long(cur);
      do_call(o);
      chk(fa == ('h100 | o), "R4 special call target", fa, 'h100 | o);
      do_ret();
      chk(fa == (cur + 1) % 4096, "R5 return after call", fa, (cur + 1) % 4096);
    end

    // R2: subroutine running off page 2 into page 3
    go_long('h17E);
    adv = 1; tick(); tick(); adv = 0;
    chk(fa == 'h180, "R2 page 2 to page 3", fa, 'h180);

    // R5: overflow overwrites the oldest entry
    go_long('h200);
    cur = 'h200;
    for (int k = 0; k < 5; k++) begin
      p[k] = cur + 1;
      do_call(k * 3);
      cur = 'h100 | (k * 3);
    end
    for (int j = 0; j < 5; j++) begin
      exp = (j < 4) ? p[4 - j] : p[4];
      do_ret();
      chk(fa == exp, "R5 overflow pop order", fa, exp);
    end

    // R7: no entry while enable is low
    iec = 1; tick(); iec = 0;
    cur = fa;
    irq = 4'hF; adv = 1; tick(); adv = 0; irq = '0;
    chk(fa == cur + 1 && ack == 0, "R7 masked when disabled", fa, cur + 1);

    // R6 / R7: every request combination
    for (int m = 1; m < 16; m++) begin
      go_long('h300 + m);
      ies = 1; tick(); ies = 0;
      chk(ien == 1, "R7 enable set", ien, 1);
      irq = 4'(m); tick(); irq = '0;
      low = 0;
      for (int b = 3; b >= 0; b--) if (m[b]) low = b;
      exp = (low == 0) ? 'h080 : (low == 1) ? 'h084 : (low == 2) ? 'h086 : 'h08C;
      chk(fa == exp, "R6 vector by priority", fa, exp);
      chk(ack == (1 << low), "R7 ack one-hot priority", ack, 1 << low);
      chk(ien == 0, "R7 enable cleared on entry", ien, 0);
      tick();
      chk(ack == 0 && fa == exp, "R6 ack single pulse", ack, 0);
      do_ret();
      chk(fa == 'h300 + m, "R6 return address pushed", fa, 'h300 + m);
    end

    // R8: interrupt wins over a strobe in the same cycle
    go_long('h455);
    ies = 1; tick(); ies = 0;
    irq = 4'b0010; jlg = 1; addr = 12'h777; tick(); jlg = 0; irq = '0;
    chk(fa == 'h084, "R8 interrupt overrides jump", fa, 'h084);
    do_ret();
    chk(fa == 'h455, "R8 strobe had no effect", fa, 'h455);

    // R10 / R11 / R12: table read over the whole map
    go_long('h5A4);
    do_call('h11);
    for (int a = 0; a < 4096; a++) begin
      treq = 1; tpg = 5'(a >> 7); tof = 7'(a & 127); trdy = 0;
      tick(); treq = 0;
      chk(tvalid == 1 && tdata == (rom_exp(a) & 255), "R10 table byte", tdata, rom_exp(a) & 255);
      chk(fa == 'h111, "R11 pc unchanged by table read", fa, 'h111);
      if (a % 8 == 0) begin
        chk(req_rdy == 0, "R12 not ready while held", req_rdy, 0);
        a2 = (a + 'h555) % 4096;
        treq = 1; tpg = 5'(a2 >> 7); tof = 7'(a2 & 127);
        tick(); treq = 0;
        chk(tvalid == 1 && tdata == (rom_exp(a) & 255), "R12 request ignored", tdata, rom_exp(a) & 255);
      end
      trdy = 1; tick(); trdy = 0;
      chk(tvalid == 0, "R10 valid drops after ready", tvalid, 0);
    end
    do_ret();
    chk(fa == 'h5A5, "R11 stack untouched by table read", fa, 'h5A5);

    // R10: back-to-back, new request taken while held byte is consumed
    treq = 1; tpg = 5'd3; tof = 7'd9; tick();
    trdy = 1; tpg = 5'd30; tof = 7'd100; tick(); treq = 0; trdy = 0;
    exp = rom_exp(30 * 128 + 100) & 255;
    chk(tvalid == 1 && tdata == exp, "R10 back-to-back accept", tdata, exp);
    trdy = 1; tick(); trdy = 0;
    chk(tvalid == 0, "R10 drained", tvalid, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule